// File: doc/BRIEF.md
# Single-Precision Floating-Point Compare and Condition Flag

This block compares two single-precision floating-point words and reports whether the first is equal to, less than, or less than or equal to the second. It also reports whether the pair is unordered. The relations are combinational. A two-bit condition select picks one of them, and a valid strobe loads the chosen result into a one-bit condition flag. A branch unit or software can then test that flag.

The ordering is not a plain integer compare. Each word is a sign bit followed by a biased 8-bit exponent and a 23-bit fraction, and the two are taken together as an unsigned magnitude. Ordering therefore goes by exponent first and fraction second. Two negative operands order in reverse. Plus and minus zero are equal. Denormals order below the smallest normal. Infinities sit at the ends of the range. Any NaN makes the pair unordered.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: A word with exponent bits 30:23 all ones and a nonzero fraction (bits 22:0) is a NaN. If either operand is a NaN, `unordered` is 1 and `is_eq`, `is_lt` and `is_le` are all 0. Otherwise `unordered` is 0.
- R2: An exponent of all ones with a zero fraction is an infinity, with bit 31 as its sign. +inf is greater than every other non-NaN value, -inf is less than every other non-NaN value, and an infinity equals the same infinity.
- R3: +0 (0x00000000) and -0 (0x80000000) compare equal, and neither is less than the other.
- R4: For two non-negative operands, the one with the larger exponent is greater. With equal exponents, the larger fraction is greater. Denormals (exponent 0, nonzero fraction) fall below every normal value.
- R5: When both operands are negative, the magnitude order of R4 is reversed.
- R6: When the signs differ and the operands are not both zero, the negative operand is the lesser.
- R7: `is_le` is 1 exactly when `is_lt` or `is_eq` is 1. `is_eq` and `is_lt` are never both 1.
- R8: `cond_sel` encodes 0 = equal, 1 = less-than, 2 = less-or-equal, 3 = unordered. When `strobe` is 1 at a rising clock edge, `cond_flag` takes the selected relation from that cycle.
- R9: When `strobe` is 0, `cond_flag` holds its value, whatever the operands and the select do.
- R10: An active-low reset `rst_n` clears `cond_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand (left side of the relation) |
| op_b | input | 32 | Second operand |
| cond_sel | input | 2 | Relation selected for the flag |
| strobe | input | 1 | Load the selected relation into the flag |
| is_eq | output | 1 | op_a equals op_b |
| is_lt | output | 1 | op_a is less than op_b |
| is_le | output | 1 | op_a is less than or equal to op_b |
| unordered | output | 1 | At least one operand is a NaN |
| cond_flag | output | 1 | Registered condition flag |

## Verification
Uniformly random 32-bit words almost never produce equal operands, signed zeros, infinities or NaNs with the fraction pattern chosen. They also almost never produce same-exponent pairs that differ only in the fraction. The stimulus therefore draws each operand from a weighted menu of classes: zeros of either sign, infinities, NaNs, denormals, normals, and a copy of the other operand with a possible sign flip or a one-unit fraction change. This makes ties, zero-sign mismatches and near-equal pairs common. Directed pairs then pin down the boundary between denormals and the smallest normal, and the ordering of negative values.

// File: rtl/fpcmp_pkg.sv
`timescale 1ns/1ps
package fpcmp_pkg;

   // Relation picked by the condition select
   typedef enum logic [1:0] {
      SEL_EQ = 2'd0,
      SEL_LT = 2'd1,
      SEL_LE = 2'd2,
      SEL_UN = 2'd3
   } rel_sel_e;

   // Bundle of the four relations produced by the order stage
   typedef struct packed {
      logic eq;
      logic lt;
      logic le;
      logic un;
   } rel_bundle_t;

endpackage

// File: rtl/fpcmp_classify.sv
`timescale 1ns/1ps
module fpcmp_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int MAG_W  = EXP_W + FRAC_W,
   localparam int WORD_W = MAG_W + 1
) (
   input  logic [WORD_W-1:0] word,
   output logic              sign,
   output logic              is_nan,
   output logic              is_zero,
   output logic [MAG_W-1:0]  mag
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_max;
   logic              exp_min;
   logic              frac_nz;

   always_comb begin
      sign    = word[WORD_W-1];
      exp_f   = word[MAG_W-1:FRAC_W];
      frac_f  = word[FRAC_W-1:0];
      exp_max = &exp_f;
      exp_min = ~|exp_f;
      frac_nz = |frac_f;
      is_nan  = exp_max & frac_nz;
      is_zero = exp_min & ~frac_nz;
      // excess-coded exponent above fraction gives a monotone magnitude
      mag     = word[MAG_W-1:0];
   end
endmodule

// File: rtl/fpcmp_order.sv
`timescale 1ns/1ps
module fpcmp_order
   import fpcmp_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic             nan_a,
   input  logic             nan_b,
   input  logic             zero_a,
   input  logic             zero_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output rel_bundle_t      rel
);
   logic mag_lt;
   logic mag_gt;
   logic mag_eq;
   logic zeros;
   logic unord;
   logic lt_ord;
   logic eq_ord;

   always_comb begin
      mag_lt = mag_a < mag_b;
      mag_gt = mag_a > mag_b;
      mag_eq = ~mag_lt & ~mag_gt;
      zeros  = zero_a & zero_b;
      unord  = nan_a | nan_b;

      eq_ord = zeros | (mag_eq & (sign_a == sign_b));

      if (zeros)
         lt_ord = 1'b0;
      else if (sign_a != sign_b)
         lt_ord = sign_a;
      else if (sign_a)
         lt_ord = mag_gt;
      else
         lt_ord = mag_lt;

      rel.un = unord;
      rel.eq = eq_ord & ~unord;
      rel.lt = lt_ord & ~unord;
      rel.le = (eq_ord | lt_ord) & ~unord;
   end
endmodule

// File: rtl/fpcmp_flag_reg.sv
`timescale 1ns/1ps
module fpcmp_flag_reg
   import fpcmp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        strobe,
   input  logic [1:0]  sel,
   input  rel_bundle_t rel,
   output logic        flag
);
   logic picked;

   always_comb begin
      unique case (rel_sel_e'(sel))
         SEL_EQ:  picked = rel.eq;
         SEL_LT:  picked = rel.lt;
         SEL_LE:  picked = rel.le;
         default: picked = rel.un;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (strobe)
         flag <= picked;
   end
endmodule

// File: rtl/fpcmp_flag_unit.sv
`timescale 1ns/1ps
module fpcmp_flag_unit
   import fpcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int MAG_W  = EXP_W + FRAC_W,
   localparam int WORD_W = MAG_W + 1,
   localparam int N_OPS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic [1:0]        cond_sel,
   input  logic              strobe,
   output logic              is_eq,
   output logic              is_lt,
   output logic              is_le,
   output logic              unordered,
   output logic              cond_flag
);
   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fpcmp_flag_unit: EXP_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("fpcmp_flag_unit: FRAC_W must be at least 1");
      end
   endgenerate

   logic [WORD_W-1:0] ops   [N_OPS];
   logic              sgn   [N_OPS];
   logic              nan   [N_OPS];
   logic              zer   [N_OPS];
   logic [MAG_W-1:0]  mag   [N_OPS];
   rel_bundle_t       rel;

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   for (genvar i = 0; i < N_OPS; i++) begin : g_cls
      fpcmp_classify #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_cls (
         .word    (ops[i]),
         .sign    (sgn[i]),
         .is_nan  (nan[i]),
         .is_zero (zer[i]),
         .mag     (mag[i])
      );
   end

   fpcmp_order #(
      .MAG_W (MAG_W)
   ) u_order (
      .sign_a (sgn[0]),
      .sign_b (sgn[1]),
      .nan_a  (nan[0]),
      .nan_b  (nan[1]),
      .zero_a (zer[0]),
      .zero_b (zer[1]),
      .mag_a  (mag[0]),
      .mag_b  (mag[1]),
      .rel    (rel)
   );

   fpcmp_flag_reg u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe),
      .sel    (cond_sel),
      .rel    (rel),
      .flag   (cond_flag)
   );

   assign is_eq     = rel.eq;
   assign is_lt     = rel.lt;
   assign is_le     = rel.le;
   assign unordered = rel.un;
endmodule

// File: rtl/fpcmp_chk.sv
`timescale 1ns/1ps
module fpcmp_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int MAG_W  = EXP_W + FRAC_W,
   localparam int WORD_W = MAG_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] op_a,
   input logic [WORD_W-1:0] op_b,
   input logic [1:0]        cond_sel,
   input logic              strobe,
   input logic              is_eq,
   input logic              is_lt,
   input logic              is_le,
   input logic              unordered,
   input logic              cond_flag
);
   logic a_nan, b_nan, a_zero, b_zero;
   assign a_nan  = (&op_a[MAG_W-1:FRAC_W]) & (|op_a[FRAC_W-1:0]);
   assign b_nan  = (&op_b[MAG_W-1:FRAC_W]) & (|op_b[FRAC_W-1:0]);
   assign a_zero = ~|op_a[MAG_W-1:0];
   assign b_zero = ~|op_b[MAG_W-1:0];

   // R1
   nan_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_nan | b_nan) |-> (unordered & ~is_eq & ~is_lt & ~is_le));

   // R3
   zero_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_zero & b_zero) |-> (is_eq & ~is_lt));

   // R7
   eq_lt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_eq && is_lt));

   // R7
   le_union_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_le == (is_eq | is_lt));

   // R6
   sign_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_a[WORD_W-1] & ~op_b[WORD_W-1] & ~a_nan & ~b_nan & ~(a_zero & b_zero)) |-> is_lt);

   // R8
   flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && cond_sel == 2'd0) |=> (cond_flag == $past(is_eq)));

   // R8
   flag_load_un_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && cond_sel == 2'd3) |=> (cond_flag == $past(unordered)));

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(cond_flag));

   // R10
   always_comb begin
      if (!rst_n) begin
         reset_clear_chk: assert (cond_flag == 1'b0);
      end
   end
endmodule

bind fpcmp_flag_unit fpcmp_chk #(
   .EXP_W  (EXP_W),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_a      (op_a),
   .op_b      (op_b),
   .cond_sel  (cond_sel),
   .strobe    (strobe),
   .is_eq     (is_eq),
   .is_lt     (is_lt),
   .is_le     (is_le),
   .unordered (unordered),
   .cond_flag (cond_flag)
);

// File: tb/tb_fpcmp_flag_unit.sv
`timescale 1ns/1ps
module tb_fpcmp_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [1:0]  cond_sel = '0;
   logic        strobe = 1'b0;
   logic        is_eq, is_lt, is_le, unordered, cond_flag;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fpcmp_flag_unit dut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .cond_sel(cond_sel), .strobe(strobe),
      .is_eq(is_eq), .is_lt(is_lt), .is_le(is_le),
      .unordered(unordered), .cond_flag(cond_flag)
   );

   localparam logic [31:0] PZERO = 32'h0000_0000;
   localparam logic [31:0] NZERO = 32'h8000_0000;
   localparam logic [31:0] PINF  = 32'h7F80_0000;
   localparam logic [31:0] NINF  = 32'hFF80_0000;
   localparam logic [31:0] QNAN  = 32'h7FC0_0000;
   localparam logic [31:0] ONE   = 32'h3F80_0000;

   function automatic bit w_nan(input logic [31:0] w);
      return (w[30:23] == 8'hFF) && (w[22:0] != 0);
   endfunction

   // signed ordering key: value of the word as sign and magnitude integer
   function automatic longint w_key(input logic [31:0] w);
      longint m = longint'(w[30:0]);
      return w[31] ? -m : m;
   endfunction

   function automatic string tag_of(input logic [31:0] a, input logic [31:0] b);
      if (w_nan(a) || w_nan(b)) return "R1";
      if (a[30:0] == 0 && b[30:0] == 0) return "R3";
      if (a[30:0] == 31'h7F80_0000 || b[30:0] == 31'h7F80_0000) return "R2";
      if (a[31] != b[31]) return "R6";
      if (a[31]) return "R5";
      return "R4";
   endfunction

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic cmp_pair(input logic [31:0] a, input logic [31:0] b);
      bit    un, e, l;
      string t;
      @(negedge clk);
      op_a = a;
      op_b = b;
      #1;
      un = w_nan(a) || w_nan(b);
      e  = !un && (w_key(a) == w_key(b));
      l  = !un && (w_key(a) <  w_key(b));
      t  = tag_of(a, b);
      chk(t, $sformatf("eq a=%h b=%h", a, b), is_eq, e);
      chk(t, $sformatf("lt a=%h b=%h", a, b), is_lt, l);
      chk("R7", $sformatf("le a=%h b=%h", a, b), is_le, e | l);
      chk("R1", $sformatf("unordered a=%h b=%h", a, b), unordered, un);
   endtask

   task automatic load_flag(input logic [31:0] a, input logic [31:0] b,
                            input logic [1:0] sel, input string req);
      bit un, e, l, exp;
      @(negedge clk);
      op_a = a; op_b = b; cond_sel = sel; strobe = 1'b1;
      un = w_nan(a) || w_nan(b);
      e  = !un && (w_key(a) == w_key(b));
      l  = !un && (w_key(a) <  w_key(b));
      case (sel)
         2'd0:    exp = e;
         2'd1:    exp = l;
         2'd2:    exp = e | l;
         default: exp = un;
      endcase
      @(negedge clk);
      strobe = 1'b0;
      chk(req, $sformatf("flag sel=%0d a=%h b=%h", sel, a, b), cond_flag, exp);
   endtask

   function automatic logic [31:0] pick(input logic [31:0] other);
      logic [31:0] r = $urandom;
      case ($urandom % 10)
         0: return {r[31], 31'h0};
         1: return {r[31], 8'hFF, 23'h0};
         2: return {r[31], 8'hFF, r[22:0] | 23'h1};
         3: return {r[31], 8'h00, r[22:0]};
         4: return other;
         5: return {~other[31], other[30:0]};
         6: return other + 32'h1;
         7: return {r[31], other[30:23], r[22:0]};
         default: return r;
      endcase
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, b;
      logic        held;
      void'($urandom(32'h1357_2468));

      // R10: flag cleared while in reset
      repeat (2) @(negedge clk);
      chk("R10", "flag in reset", cond_flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "flag after reset", cond_flag, 1'b0);

      // directed corner cases
      cmp_pair(PZERO, NZERO);                        // R3
      cmp_pair(NZERO, PZERO);                        // R3
      cmp_pair(QNAN, ONE);                           // R1
      cmp_pair(ONE, 32'hFF80_0001);                  // R1
      cmp_pair(QNAN, QNAN);                          // R1
      cmp_pair(PINF, PINF);                          // R2
      cmp_pair(NINF, 32'hFF7F_FFFF);                 // R2
      cmp_pair(32'h7F7F_FFFF, PINF);                 // R2
      cmp_pair(32'h007F_FFFF, 32'h0080_0000);        // R4 denormal below min normal
      cmp_pair(32'h0000_0001, PZERO);                // R4
      cmp_pair(32'h3F80_0001, ONE);                  // R4 fraction decides
      cmp_pair(32'h4000_0000, 32'h3FFF_FFFF);        // R4 exponent decides
      cmp_pair(32'hC0A0_0000, 32'hBF40_0000);        // R5 -5 < -0.75
      cmp_pair(32'h8000_0001, NZERO);                // R5
      cmp_pair(32'h8000_0001, 32'h0000_0001);        // R6
      cmp_pair(PZERO, 32'h8000_0001);                // R6

      // R8 each select encoding
      load_flag(ONE, ONE, 2'd0, "R8");
      load_flag(NZERO, ONE, 2'd1, "R8");
      load_flag(ONE, NZERO, 2'd1, "R8");
      load_flag(ONE, ONE, 2'd2, "R8");
      load_flag(QNAN, ONE, 2'd3, "R8");
      load_flag(ONE, ONE, 2'd3, "R8");
      load_flag(QNAN, QNAN, 2'd2, "R8");

      // R9: hold without strobe across operand and select changes
      load_flag(NINF, PINF, 2'd1, "R8");
      held = cond_flag;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         op_a = PINF; op_b = NINF; cond_sel = 2'(k); strobe = 1'b0;
         @(negedge clk);
         chk("R9", $sformatf("flag hold step %0d", k), cond_flag, held);
      end

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         a = $urandom;
         b = pick(a);
         if ($urandom % 2) cmp_pair(a, b);
         else              cmp_pair(b, a);
      end
      for (int i = 0; i < 300; i++) begin
         a = $urandom;
         b = pick(a);
         load_flag(a, b, 2'($urandom % 4), "R8");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule